// File: doc/BRIEF.md
# Host Memory Window Decoder

This block decodes host-bus memory addresses against four programmable windows. Each window has its own base register, holding an upper-address compare value and a per-bit mask. A control register turns each window on and marks which windows answer as 16-bit memory. For every host address the block reports whether an enabled window matched, which window won, and whether the 16-bit memory-cycle indication (M16) should be driven.

A single I/O-mode bit in the control register switches the host interface to I/O mapping and shuts off all memory windows, whatever their enable bits hold. Window 3's enable comes out of reset from a boot-ROM strap pin, so a system can boot with that window already live.

A self-clearing soft-reset bit in the control register produces a reset pulse on a dedicated output. The pulse lasts a fixed minimum number of local clock cycles.

The decode path from address to outputs is combinational. Register writes take effect at the next rising clock edge, and register reads are combinational.

Top module: `mem_window_decoder`

## Requirements
- R1: Window n (n = 0..3) hits when its enable bit is 1, the I/O-mode bit is 0, and ((addr_i[ADDR_W-1:ADDR_W-8] XOR base_n) AND mask_n) == 0. hit_o is 1 exactly when some window hits.
- R2: When the I/O-mode bit (control bit 8) is 1, hit_o and m16_o are both 0 for every address.
- R3: After reset the I/O-mode bit reads 0.
- R4: m16_o is 1 only when a window hits and the winning window has both its 16-bit flag (control bit 4+n) and its enable bit (control bit n) at 1.
- R5: After reset all four 16-bit flags (control bits 7:4) read 0.
- R6: After reset enable bits 2..0 read 0, and enable bit 3 reads the level of bios_en_i while rst_ni was low.
- R7: A write of 1 to control bit 9 drives srst_o high from the first rising edge after the write for exactly RST_CYC (default 4) cycles. A new such write while the pulse runs restarts the full count.
- R8: When several windows hit, the lowest-numbered one wins: hit_idx_o gives its number and its flags decide m16_o. hit_idx_o is 0 when nothing hits.
- R9: The control register is at reg_addr_i = 0. Bits 3:0 are the enables, 7:4 the 16-bit flags, 8 the I/O-mode bit and 9 the soft-reset bit. Reads return bits 8:0 as written and bits 15:9 as 0.
- R10: Base register n is at reg_addr_i = n+1, with bits 7:0 the compare value and bits 15:8 the mask. It reads back as written and resets to 0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bios_en_i | input | 1 | Strap giving window 3's enable at reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| addr_i | input | ADDR_W | Host address |
| hit_o | output | 1 | An enabled window matched |
| hit_idx_o | output | 2 | Number of the winning window |
| m16_o | output | 1 | 16-bit memory-cycle indication |
| srst_o | output | 1 | Soft-reset output pulse |

## Verification
Some properties are checked on every cycle: the I/O-mode bit blocks every hit and every M16, M16 never appears without a hit on a window that is enabled and flagged as 16-bit, the winning window actually matched and no lower-numbered window did, and a soft-reset pulse never ends before its minimum length.

Other behaviour can only be shown by the bench's scenarios. These are the exact pulse length and the restart of the count, the reset values (including the strap loading), read-back of the registers, and the full sweep of addresses against every combination of enables, 16-bit flags and I/O mode over overlapping windows.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
  localparam int unsigned NUM_WIN = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_WIN);
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CMP_W   = 8;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned EN_LSB  = 0;
  localparam int unsigned W16_LSB = NUM_WIN;
  localparam int unsigned IO_BIT  = 2 * NUM_WIN;
  localparam int unsigned SR_BIT  = IO_BIT + 1;
  localparam logic [REG_AW-1:0] CTRL_ADDR = '0;

  typedef logic [CMP_W-1:0] cmp_t;
endpackage

// File: rtl/win_ctrl_reg.sv
module win_ctrl_reg
  import win_dec_pkg::*;
#(
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bios_en_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_WIN-1:0] en_o,
  output logic [NUM_WIN-1:0] w16_o,
  output logic              io_o,
  output logic              srst_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= {bios_en_i, {(NUM_WIN-1){1'b0}}};
      w16_o <= '0;
      io_o  <= 1'b0;
    end else if (we_i) begin
      en_o  <= wdata_i[EN_LSB +: NUM_WIN];
      w16_o <= wdata_i[W16_LSB +: NUM_WIN];
      io_o  <= wdata_i[IO_BIT];
    end
  end

  // soft-reset bit is never stored; it only loads the pulse counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (we_i && wdata_i[SR_BIT]) cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign srst_o = (cnt_q != '0);

  always_comb begin
    rdata_o = '0;
    rdata_o[EN_LSB +: NUM_WIN]  = en_o;
    rdata_o[W16_LSB +: NUM_WIN] = w16_o;
    rdata_o[IO_BIT]             = io_o;
  end

  // pulse-length checker
  logic [CNT_W-1:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hi_len_q <= '0;
    else if (!srst_o)                    hi_len_q <= '0;
    else if (hi_len_q != {CNT_W{1'b1}})  hi_len_q <= hi_len_q + 1'b1;
  end

  p_srst_min_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_o && hi_len_q != '0) |-> (hi_len_q >= CNT_LOAD));

  p_srst_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[SR_BIT]) |=> srst_o);
endmodule

// File: rtl/win_base_bank.sv
module win_base_bank
  import win_dec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WIN-1:0] we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output cmp_t               base_o [NUM_WIN],
  output cmp_t               mask_o [NUM_WIN]
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
        mask_o[g] <= '0;
      end else if (we_i[g]) begin
        base_o[g] <= wdata_i[CMP_W-1:0];
        mask_o[g] <= wdata_i[2*CMP_W-1:CMP_W];
      end
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import win_dec_pkg::*;
(
  input  cmp_t               addr_hi_i,
  input  cmp_t               base_i [NUM_WIN],
  input  cmp_t               mask_i [NUM_WIN],
  input  logic [NUM_WIN-1:0] en_i,
  input  logic               io_i,
  output logic [NUM_WIN-1:0] hit_vec_o
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit_vec_o[g] = en_i[g] && !io_i &&
                          (((addr_hi_i ^ base_i[g]) & mask_i[g]) == '0);
  end
endmodule

// File: rtl/win_arbiter.sv
module win_arbiter
  import win_dec_pkg::*;
(
  input  logic [NUM_WIN-1:0] hit_vec_i,
  input  logic [NUM_WIN-1:0] w16_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               m16_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec_i;
  assign m16_o = hit_o && w16_i[idx_o];
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import win_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bios_en_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [1:0]        hit_idx_o,
  output logic              m16_o,
  output logic              srst_o
);
  logic [NUM_WIN-1:0] en, w16, base_we, hit_vec;
  logic               io_mode, ctrl_we;
  logic [DATA_W-1:0]  ctrl_rdata;
  cmp_t               base [NUM_WIN];
  cmp_t               mask [NUM_WIN];

  assign ctrl_we = reg_we_i && (reg_addr_i == CTRL_ADDR);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_we
    assign base_we[g] = reg_we_i && (reg_addr_i == REG_AW'(g + 1));
  end

  win_ctrl_reg #(.RST_CYC(RST_CYC)) u_ctrl (
    .clk_i, .rst_ni, .bios_en_i,
    .we_i(ctrl_we), .wdata_i(reg_wdata_i),
    .en_o(en), .w16_o(w16), .io_o(io_mode),
    .srst_o, .rdata_o(ctrl_rdata)
  );

  win_base_bank u_bank (
    .clk_i, .rst_ni, .we_i(base_we), .wdata_i(reg_wdata_i),
    .base_o(base), .mask_o(mask)
  );

  win_match u_match (
    .addr_hi_i(addr_i[ADDR_W-1 -: CMP_W]), .base_i(base), .mask_i(mask),
    .en_i(en), .io_i(io_mode), .hit_vec_o(hit_vec)
  );

  win_arbiter u_arb (
    .hit_vec_i(hit_vec), .w16_i(w16),
    .hit_o, .idx_o(hit_idx_o), .m16_o
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == CTRL_ADDR) begin
      reg_rdata_o = ctrl_rdata;
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (reg_addr_i == REG_AW'(i + 1)) reg_rdata_o = {mask[i], base[i]};
      end
    end
  end

  p_io_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_mode |-> (!hit_o && !m16_o));

  p_m16_qualified_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m16_o |-> (hit_o && w16[hit_idx_o] && en[hit_idx_o]));

  p_hit_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (en[hit_idx_o] && !io_mode));

  p_winner_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_vec[hit_idx_o] &&
               ((hit_vec & ((NUM_WIN'(1) << hit_idx_o) - 1'b1)) == '0)));

  p_idx_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0));
endmodule

// File: tb/mem_window_decoder_test.sv
`timescale 1ns/1ps
module mem_window_decoder_test;
  localparam int ADDR_W = 20;
  localparam int RST_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0, bios_en = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [ADDR_W-1:0] addr = '0;
  logic hit, m16, srst;
  logic [1:0] hit_idx;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mem_window_decoder #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bios_en_i(bios_en),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .addr_i(addr), .hit_o(hit),
    .hit_idx_o(hit_idx), .m16_o(m16), .srst_o(srst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // window configuration: overlapping pairs 0/1 and 2/3
  logic [7:0] cfg_base [4] = '{8'h40, 8'h48, 8'hC0, 8'hF0};
  logic [7:0] cfg_mask [4] = '{8'hF0, 8'hF8, 8'hC0, 8'hF0};

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    // reset with strap high
    bios_en = 1'b1;
    #12; @(negedge clk); rst_n = 1'b1;
    rd(3'd0, d);
    chk("R6 en3 from strap=1", {16'h0, d}, 32'h0008);
    chk("R3 io mode reset", {31'h0, d[8]}, 32'h0);
    chk("R5 w16 reset", {28'h0, d[7:4]}, 32'h0);
    chk("R7 srst idle after reset", {31'h0, srst}, 32'h0);
    for (int i = 1; i <= 4; i++) begin
      rd(3'(i), d);
      chk("R10 base reset", {16'h0, d}, 32'h0);
    end
    // reset with strap low
    rst_n = 1'b0; bios_en = 1'b0; #7;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0, d);
    chk("R6 en3 from strap=0", {16'h0, d}, 32'h0);

    // R10 read-back
    for (int i = 0; i < 4; i++) wr(3'(i + 1), {cfg_mask[i], cfg_base[i]});
    for (int i = 0; i < 4; i++) begin
      rd(3'(i + 1), d);
      chk("R10 base readback", {16'h0, d}, {16'h0, cfg_mask[i], cfg_base[i]});
    end
    for (int i = 5; i <= 7; i++) begin
      rd(3'(i), d);
      chk("R10 unmapped reads 0", {16'h0, d}, 32'h0);
    end

    // R9 control read-back masks soft-reset and upper bits
    wr(3'd0, 16'hFEA5);
    rd(3'd0, d);
    chk("R9 ctrl readback", {16'h0, d}, 32'h00A5);
    repeat (RST_CYC + 2) @(negedge clk);

    // R7 pulse length
    wr(3'd0, 16'h0200);
    chk("R7 srst cycle 1", {31'h0, srst}, 32'h1);
    for (int k = 2; k <= RST_CYC; k++) begin
      @(negedge clk);
      chk("R7 srst held", {31'h0, srst}, 32'h1);
    end
    @(negedge clk);
    chk("R7 srst ends", {31'h0, srst}, 32'h0);
    rd(3'd0, d);
    chk("R9 sr bit reads 0", {31'h0, d[9]}, 32'h0);

    // R7 restart during pulse
    wr(3'd0, 16'h0200);
    @(negedge clk);
    wr(3'd0, 16'h0200);
    for (int k = 1; k <= RST_CYC; k++) begin
      chk("R7 srst restarted", {31'h0, srst}, 32'h1);
      @(negedge clk);
    end
    chk("R7 srst ends after restart", {31'h0, srst}, 32'h0);

    // exhaustive sweep: enables x 16-bit flags x io mode x upper address
    for (int io = 0; io < 2; io++) begin
      for (int en = 0; en < 16; en++) begin
        for (int w = 0; w < 16; w++) begin
          wr(3'd0, 16'((io << 8) | (w << 4) | en));
          for (int a = 0; a < 256; a++) begin
            logic exp_hit, exp_m16;
            logic [1:0] exp_idx;
            exp_hit = 1'b0; exp_m16 = 1'b0; exp_idx = 2'd0;
            for (int n = 3; n >= 0; n--) begin
              if (io == 0 && en[n] && (((8'(a) ^ cfg_base[n]) & cfg_mask[n]) == 8'h0)) begin
                exp_hit = 1'b1; exp_idx = 2'(n); exp_m16 = w[n];
              end
            end
            addr = {8'(a), 12'h5A3 ^ 12'(a)};
            #1;
            if (io != 0) chk("R2 io mode blocks", {30'h0, hit, m16}, 32'h0);
            else begin
              chk("R1 hit", {31'h0, hit}, {31'h0, exp_hit});
              chk("R8 winner index", {30'h0, hit_idx}, {30'h0, exp_idx});
              chk("R4 m16", {31'h0, m16}, {31'h0, exp_m16});
            end
          end
        end
      end
    end
    finish_up();
  end
endmodule